// File: doc/BRIEF.md
# On/Off Delay Timer

This block delays both edges of a single digital trigger. When the trigger goes high, the output follows only after the trigger has stayed high for a programmable number of timebase ticks. When the trigger goes low, the output follows only after the trigger has stayed low for a second, independent number of ticks. If the trigger reverses before the running interval completes, that interval is abandoned and its count is cleared. The output then keeps its level, and a later edge restarts timing from zero.

Both delays are run-time inputs, so a controller can retune them without a reset. They are counted in ticks of a clock-enable timebase rather than in raw clock cycles, which lets one fast clock drive timers with long delays. The trigger may come from another clock domain. It passes through a two-flop synchronizer before any edge is detected.

Top module: `onoff_delay_timer`

## Requirements
- R1: While `rst` is high at a rising clock edge, `outQ` is 0 after that edge, and both interval counts are cleared.
- R2: After the synchronized trigger rises while `outQ` is 0, with `onDelay` = N > 0 and `tickEn` high every cycle, `outQ` rises N+1 clocks after the synchronized level changes, which is N+3 clocks after `trigIn` changes. The clock that starts the interval is not counted as a tick.
- R3: If the trigger returns to 0 before the on interval completes, `outQ` stays 0 and the partial count is discarded. A later rising edge times the full `onDelay` again.
- R4: After the synchronized trigger falls while `outQ` is 1, with `offDelay` = N > 0 and `tickEn` high every cycle, `outQ` falls N+3 clocks after `trigIn` changes.
- R5: If the trigger returns to 1 before the off interval completes, `outQ` stays 1 and the partial count is discarded.
- R6: A delay value of 0 makes the matching `outQ` edge follow one clock after the synchronized trigger edge, which is three clocks after `trigIn` changes.
- R7: Interval counts advance only on clocks where `tickEn` is 1. While `tickEn` is 0, a pending interval neither advances nor completes.
- R8: `rst` asserted in the middle of an interval or while `outQ` is 1 drives `outQ` to 0 on the next clock. After reset is released, the synchronizer restarts from 0.
- R9: `trigIn` is sampled through two flops before edge detection, so no change on `trigIn` reaches `outQ` in fewer than three clocks.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| tickEn | input | 1 | Timebase enable; one tick per clock where high |
| trigIn | input | 1 | Trigger input, may be asynchronous |
| onDelay | input | 16 | Ticks the trigger must hold 1 before `outQ` rises |
| offDelay | input | 16 | Ticks the trigger must hold 0 before `outQ` falls |
| outQ | output | 1 | Delayed output |

## Verification
A stuck or mis-cleared counter shows up at the first edge that follows a cancelled interval. The output changes early or late by the number of leftover ticks, and that error appears within one delay period. A state machine that mishandles a trigger reversal either lets through a pulse that should have been filtered or misses an edge. This shows at `outQ` at most `delay + 3` clocks after the reversal. Wrong synchronizer depth shifts every edge of `outQ` by whole clocks, so cycle-exact checks of the zero-delay latency expose it at once.

// File: rtl/timer_pkg.sv
package timer_pkg;

  // Phase of the timer as seen by the control path.
  typedef enum logic [1:0] {
    ST_LOW     = 2'b00,  // output 0, trigger settled at 0
    ST_ONWAIT  = 2'b01,  // output 0, timing the on interval
    ST_HIGH    = 2'b10,  // output 1, trigger settled at 1
    ST_OFFWAIT = 2'b11   // output 1, timing the off interval
  } timerState_t;

  // Strobes from control to the counting datapath.
  typedef struct packed {
    logic clr;     // return count to zero
    logic inc;     // advance count by one tick
    logic selOff;  // compare against the off-delay limit
  } cntStrobe_t;

endpackage

// File: rtl/dt_sync.sv
module dt_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic asyncIn,
  output logic syncOut
);

  logic [STAGES-1:0] stageQ;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) stageQ[i] <= 1'b0;
          else     stageQ[i] <= asyncIn;
        end
      end else begin : g_rest
        always_ff @(posedge clk) begin
          if (rst) stageQ[i] <= 1'b0;
          else     stageQ[i] <= stageQ[i-1];
        end
      end
    end
  endgenerate

  assign syncOut = stageQ[STAGES-1];

  // The first clock after reset must still present the cleared value.
  AST_SYNC_CLEARED: assert property (@(posedge clk)
    rst |=> !syncOut)
    else $error("synchronizer not cleared");  // R8

endmodule

// File: rtl/dt_datapath.sv
module dt_datapath
  import timer_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  cntStrobe_t       strobe,
  input  logic [CNT_W-1:0] onDelay,
  input  logic [CNT_W-1:0] offDelay,
  output logic             limZero,
  output logic             lastTick
);

  localparam int EXT_W = CNT_W + 1;

  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] limit;
  logic [EXT_W-1:0] cntNext;

  assign limit    = strobe.selOff ? offDelay : onDelay;
  assign limZero  = (limit == '0);
  assign cntNext  = {1'b0, cnt} + EXT_W'(1);
  // True when the tick taken this cycle would complete the interval.
  assign lastTick = (cntNext >= {1'b0, limit});

  always_ff @(posedge clk) begin
    if (rst || strobe.clr) cnt <= '0;
    else if (strobe.inc)   cnt <= cntNext[CNT_W-1:0];
  end

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
    strobe.inc |-> (cnt != '1))
    else $error("count would wrap");  // R7

  AST_CLEAR_WINS: assert property (@(posedge clk) disable iff (rst)
    strobe.clr |=> (cnt == '0))
    else $error("count not cleared");  // R3

  AST_INC_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
    !(strobe.clr && strobe.inc))
    else $error("clear and advance together");  // R5

endmodule

// File: rtl/dt_ctrl.sv
module dt_ctrl
  import timer_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       tickEn,
  input  logic       trigSync,
  input  logic       limZero,
  input  logic       lastTick,
  output cntStrobe_t strobe,
  output logic       outQ
);

  timerState_t state, stateNxt;

  always_comb begin
    stateNxt      = state;
    strobe        = '0;
    strobe.selOff = (state == ST_HIGH) || (state == ST_OFFWAIT);
    unique case (state)
      ST_LOW: begin
        if (trigSync) begin
          strobe.clr = 1'b1;
          stateNxt   = limZero ? ST_HIGH : ST_ONWAIT;
        end
      end
      ST_ONWAIT: begin
        if (!trigSync) begin
          strobe.clr = 1'b1;
          stateNxt   = ST_LOW;
        end else if (tickEn) begin
          if (lastTick) begin
            strobe.clr = 1'b1;
            stateNxt   = ST_HIGH;
          end else begin
            strobe.inc = 1'b1;
          end
        end
      end
      ST_HIGH: begin
        if (!trigSync) begin
          strobe.clr = 1'b1;
          stateNxt   = limZero ? ST_LOW : ST_OFFWAIT;
        end
      end
      ST_OFFWAIT: begin
        if (trigSync) begin
          strobe.clr = 1'b1;
          stateNxt   = ST_HIGH;
        end else if (tickEn) begin
          if (lastTick) begin
            strobe.clr = 1'b1;
            stateNxt   = ST_LOW;
          end else begin
            strobe.inc = 1'b1;
          end
        end
      end
      default: begin
        strobe.clr = 1'b1;
        stateNxt   = ST_LOW;
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) state <= ST_LOW;
    else     state <= stateNxt;
  end

  assign outQ = (state == ST_HIGH) || (state == ST_OFFWAIT);

  AST_RISE_NEEDS_HIGH: assert property (@(posedge clk) disable iff (rst)
    $rose(outQ) |-> $past(trigSync))
    else $error("output rose without trigger high");  // R2

  AST_FALL_NEEDS_LOW: assert property (@(posedge clk) disable iff (rst)
    $fell(outQ) |-> ($past(rst) || !$past(trigSync)))
    else $error("output fell without trigger low");  // R4

  AST_RESET_CLEARS: assert property (@(posedge clk)
    rst |=> !outQ)
    else $error("output not cleared by reset");  // R1

  AST_TICK_HOLD_ON: assert property (@(posedge clk) disable iff (rst)
    (state == ST_ONWAIT && trigSync && !tickEn) |=> (state == ST_ONWAIT))
    else $error("on interval moved without tick");  // R7

  AST_TICK_HOLD_OFF: assert property (@(posedge clk) disable iff (rst)
    (state == ST_OFFWAIT && !trigSync && !tickEn) |=> (state == ST_OFFWAIT))
    else $error("off interval moved without tick");  // R7

endmodule

// File: rtl/onoff_delay_timer.sv
module onoff_delay_timer
  import timer_pkg::*;
#(
  parameter int CNT_W       = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tickEn,
  input  logic             trigIn,
  input  logic [CNT_W-1:0] onDelay,
  input  logic [CNT_W-1:0] offDelay,
  output logic             outQ
);

  logic       trigSync;
  logic       limZero;
  logic       lastTick;
  cntStrobe_t strobe;

  dt_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk     (clk),
    .rst     (rst),
    .asyncIn (trigIn),
    .syncOut (trigSync)
  );

  dt_ctrl u_ctrl (
    .clk      (clk),
    .rst      (rst),
    .tickEn   (tickEn),
    .trigSync (trigSync),
    .limZero  (limZero),
    .lastTick (lastTick),
    .strobe   (strobe),
    .outQ     (outQ)
  );

  dt_datapath #(.CNT_W(CNT_W)) u_dp (
    .clk      (clk),
    .rst      (rst),
    .strobe   (strobe),
    .onDelay  (onDelay),
    .offDelay (offDelay),
    .limZero  (limZero),
    .lastTick (lastTick)
  );

endmodule

// File: tb/onoff_delay_timer_tb_top.sv
`timescale 1ns/1ps
module onoff_delay_timer_tb_top;

  logic        clk = 1'b0;
  logic        rst;
  logic        tickEn;
  logic        trigIn;
  logic [15:0] onDelay;
  logic [15:0] offDelay;
  logic        outQ;

  int    nChecks = 0;
  int    nFails  = 0;
  int    cycles  = 0;
  bit    cmpOn   = 1'b0;
  string curReq  = "R1";

  // reference model state
  logic        m1, m2, eOut, eWait;
  logic [16:0] eCnt;
  logic [15:0] eLim;

  always #2.5 clk = ~clk;  // 200 MHz

  onoff_delay_timer dut_i (
    .clk(clk), .rst(rst), .tickEn(tickEn), .trigIn(trigIn),
    .onDelay(onDelay), .offDelay(offDelay), .outQ(outQ)
  );

  function automatic logic intervalDone(logic [16:0] cnt, logic [15:0] lim);
    return (cnt + 17'd1) >= {1'b0, lim};
  endfunction

  task automatic check(string req, logic act, logic exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: outQ=%0b expected %0b at cycle %0d", req, act, exp, cycles);
    end
  endtask

  // Expected behaviour built from the requirements.
  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (rst) begin
      m1 <= 1'b0; m2 <= 1'b0; eOut <= 1'b0; eWait <= 1'b0; eCnt <= '0;
    end else begin
      m1 <= trigIn;
      m2 <= m1;
      eLim = eOut ? offDelay : onDelay;
      if (m2 == eOut) begin
        eWait <= 1'b0; eCnt <= '0;
      end else if (!eWait) begin
        if (eLim == 16'd0) eOut <= m2;
        else begin eWait <= 1'b1; eCnt <= '0; end
      end else if (tickEn) begin
        if (intervalDone(eCnt, eLim)) begin
          eOut <= m2; eWait <= 1'b0; eCnt <= '0;
        end else eCnt <= eCnt + 17'd1;
      end
    end
  end

  always @(negedge clk) begin
    if (cmpOn && !rst) check(curReq, outQ, eOut);
  end

  task automatic cyc(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  initial begin : watchdog
    #(5.0 * 150000);
    nFails++;
    $display("FAIL watchdog: run did not complete, actual hung expected done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

  initial begin
    void'($urandom(32'd24681));
    rst = 1'b1; tickEn = 1'b1; trigIn = 1'b0; onDelay = 16'd5; offDelay = 16'd4;
    cyc(3);
    check("R1", outQ, 1'b0);  // reset state
    rst = 1'b0;
    cyc(4);
    cmpOn = 1'b1;

    // R2: exact on-delay latency, N=5
    curReq = "R2";
    trigIn = 1'b1;
    cyc(7); check("R2", outQ, 1'b0);
    cyc(1); check("R2", outQ, 1'b1);
    cyc(5);

    // R4: exact off-delay latency, N=4
    curReq = "R4";
    trigIn = 1'b0;
    cyc(6); check("R4", outQ, 1'b1);
    cyc(1); check("R4", outQ, 1'b0);
    cyc(5);

    // R3: short high pulse filtered, then full delay retimed
    curReq = "R3";
    trigIn = 1'b1; cyc(5); trigIn = 1'b0; cyc(12);
    check("R3", outQ, 1'b0);
    trigIn = 1'b1;
    cyc(7); check("R3", outQ, 1'b0);
    cyc(1); check("R3", outQ, 1'b1);

    // R5: short low pulse filtered
    curReq = "R5";
    trigIn = 1'b0; cyc(4); trigIn = 1'b1; cyc(12);
    check("R5", outQ, 1'b1);

    // R6/R9: zero delays, three clocks from pin to output
    curReq = "R6";
    offDelay = 16'd0; onDelay = 16'd0;
    trigIn = 1'b0;
    cyc(2); check("R9", outQ, 1'b1);
    cyc(1); check("R6", outQ, 1'b0);
    trigIn = 1'b1;
    cyc(2); check("R9", outQ, 1'b0);
    cyc(1); check("R6", outQ, 1'b1);
    trigIn = 1'b0; cyc(4);

    // R7: no ticks, interval frozen
    curReq = "R7";
    onDelay = 16'd2; tickEn = 1'b0;
    trigIn = 1'b1; cyc(30);
    check("R7", outQ, 1'b0);
    tickEn = 1'b1;
    cyc(2); check("R7", outQ, 1'b1);

    // R8: reset while output high
    curReq = "R8";
    rst = 1'b1; cyc(1);
    check("R8", outQ, 1'b0);
    rst = 1'b0; trigIn = 1'b0; cyc(6);
    check("R8", outQ, 1'b0);

    // Random phase against the model
    curReq = "R2/R3/R4/R5/R7";
    for (int k = 0; k < 6000; k++) begin
      if (k % 500 == 0) begin
        onDelay  = 16'($urandom % 10);
        offDelay = 16'($urandom % 10);
      end
      tickEn = ($urandom % 3) != 0;
      if (($urandom % 8) == 0) trigIn = ~trigIn;
      cyc(1);
    end

    cmpOn = 1'b0;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

endmodule